// File: doc/BRIEF.md
# Fetch Target Predictor

This block guesses the address that instruction fetch should use next, working only from the address being fetched now. A direct-mapped table, indexed by low bits of the fetch address, holds one entry per slot: a valid flag, the complete address of a branch and the target that branch last went to. The lookup is combinational in the fetch cycle. When the slot is valid and its stored branch address equals the fetch address in every bit, fetch is redirected to the stored target. In every other case fetch moves on to the next sequential word.

A small stack of return addresses handles function returns separately from the table. The fetch stage flags a fetch that is a return, and the block then offers the top of the stack. Update ports take resolved branches, with address, target and taken flag, and take call and return events that push and pop the stack. An entry in the table is the only direction information: an address that is present predicts taken.

Top module: `fetch_target_predictor`

## Requirements
- R1: After reset every table entry is invalid and the return stack is empty: `next_pc` is `fetch_pc + 4`, `redirect` and `from_stack` are 0, and `stack_valid` is 0.
- R2: The table slot is chosen by `fetch_pc[7:2]` (6 index bits at the default of 64 entries). The slot hits only when it is valid and its stored branch address equals `fetch_pc` in all 32 bits. An address with the same index but different upper bits is a miss.
- R3: On a table hit, `next_pc` equals the stored target and `redirect` is 1.
- R4: When there is no hit and no stack prediction, `next_pc` is `fetch_pc + 4` and `redirect` is 0.
- R5: A resolved taken branch (`res_valid` and `res_taken`) writes valid, address and target into its slot, replacing any earlier content. The new entry is visible to a lookup in the next cycle.
- R6: A resolved not-taken branch clears its slot only when the slot is valid and holds the same branch address. If the stored address differs, the slot is unchanged.
- R7: `call_valid` pushes `call_pc + 4`. When `fetch_is_ret` is 1 and the stack is not empty, `next_pc` is the top of the stack, and `redirect` and `from_stack` are 1. This takes priority over a table hit.
- R8: The stack holds 8 addresses. A push onto a full stack overwrites the oldest address. Pops return the newest 8 addresses in last-in, first-out order.
- R9: `ret_valid` pops the stack. A pop on an empty stack leaves it empty. When the stack is empty, `stack_valid` is 0 and a fetch flagged as a return is predicted from the table or sequentially.
- R10: When `call_valid` and `ret_valid` arrive in the same cycle, the top address is replaced by `call_pc + 4` and the depth stays the same. On an empty stack the new address is simply pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address being fetched |
| fetch_is_ret | input | 1 | The fetched instruction is a return |
| next_pc | output | 32 | Predicted next fetch address |
| redirect | output | 1 | Prediction is not sequential |
| from_stack | output | 1 | Prediction came from the return stack |
| stack_valid | output | 1 | Return stack is not empty |
| res_valid | input | 1 | Resolved branch update strobe |
| res_pc | input | 32 | Resolved branch address |
| res_target | input | 32 | Resolved branch target |
| res_taken | input | 1 | Resolved branch was taken |
| call_valid | input | 1 | Call event, pushes call_pc + 4 |
| call_pc | input | 32 | Address of the call |
| ret_valid | input | 1 | Return event, pops the stack |

## Verification
The table is tested with directed patterns that separate the hit cases:
- an exact address match against an alias with the same index but different upper bits;
- a not-taken update whose address differs, which must leave the slot alone, against one whose address matches, which must clear it;
- a rewrite of a slot that already holds an entry.

The stack is tested with a run of ten pushes and then ten pops. This run shows that overflow drops the oldest addresses, that the order is last in, first out, and that pops on an empty stack are harmless. A combined call and return on a full stack and on an empty stack separates replacing the top from pushing. A long constrained-random run draws fetch addresses from two upper-bit pages so that aliasing is frequent, and mixes in updates, calls and returns. It checks each cycle against a bench model built from the requirements.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

    typedef enum logic [1:0] {
        SRC_SEQ   = 2'd0,
        SRC_TABLE = 2'd1,
        SRC_STACK = 2'd2
    } pred_src_e;

endpackage

// File: rtl/ftp_table.sv
module ftp_table #(
    parameter int N_ENTRIES = 64,
    parameter int PC_W      = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_target,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic [PC_W-1:0] up_target,
    input  logic            up_taken
);
    localparam int IDX_W = $clog2(N_ENTRIES);

    typedef struct packed {
        logic [N_ENTRIES-1:0]           vld;
        logic [N_ENTRIES-1:0][PC_W-1:0] tag;
        logic [N_ENTRIES-1:0][PC_W-1:0] tgt;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] up_idx;
    logic             up_tag_eq;

    assign lk_idx    = lk_pc[IDX_W+1:2];
    assign up_idx    = up_pc[IDX_W+1:2];
    assign up_tag_eq = st_q.vld[up_idx] && (st_q.tag[up_idx] == up_pc);

    assign lk_hit    = st_q.vld[lk_idx] && (st_q.tag[lk_idx] == lk_pc);
    assign lk_target = st_q.tgt[lk_idx];

    always_comb begin
        st_d = st_q;
        if (up_valid) begin
            if (up_taken) begin
                st_d.vld[up_idx] = 1'b1;
                st_d.tag[up_idx] = up_pc;
                st_d.tgt[up_idx] = up_target;
            end else if (up_tag_eq) begin
                st_d.vld[up_idx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_taken_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken) |=>
            (st_q.vld[$past(up_idx)] && st_q.tag[$past(up_idx)] == $past(up_pc)
             && st_q.tgt[$past(up_idx)] == $past(up_target)));

    p_nt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && up_tag_eq) |=> !st_q.vld[$past(up_idx)]);

    p_nt_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && !up_tag_eq) |=>
            (st_q.vld[$past(up_idx)] == $past(st_q.vld[up_idx])));

endmodule

// File: rtl/ftp_ras.sv
module ftp_ras #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [PC_W-1:0] push_addr,
    input  logic            pop,
    output logic [PC_W-1:0] top_addr,
    output logic            top_valid
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] stk;
        logic [PTR_W-1:0]           ptr;
        logic [CNT_W-1:0]           cnt;
    } ras_state_t;

    ras_state_t st_d, st_q;

    logic [PTR_W-1:0] ptr_up;
    logic [PTR_W-1:0] ptr_dn;

    assign ptr_up    = (st_q.ptr == PTR_MAX) ? '0 : st_q.ptr + 1'b1;
    assign ptr_dn    = (st_q.ptr == '0) ? PTR_MAX : st_q.ptr - 1'b1;
    assign top_addr  = st_q.stk[st_q.ptr];
    assign top_valid = (st_q.cnt != '0);

    always_comb begin
        st_d = st_q;
        if (push && pop && top_valid) begin
            st_d.stk[st_q.ptr] = push_addr;
        end else if (push) begin
            st_d.ptr         = ptr_up;
            st_d.stk[ptr_up] = push_addr;
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop && top_valid) begin
            st_d.ptr = ptr_dn;
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);

    p_push_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (top_valid && top_addr == $past(push_addr)));

    p_push_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && st_q.cnt != CNT_MAX) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !top_valid) |=> !top_valid);

    p_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && top_valid) |=>
            (st_q.cnt == $past(st_q.cnt) && top_addr == $past(push_addr)));

endmodule

// File: rtl/fetch_target_predictor.sv
module fetch_target_predictor #(
    parameter int N_ENTRIES = 64,
    parameter int PC_W      = 32,
    parameter int RAS_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            fetch_is_ret,
    output logic [PC_W-1:0] next_pc,
    output logic            redirect,
    output logic            from_stack,
    output logic            stack_valid,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic [PC_W-1:0] res_target,
    input  logic            res_taken,
    input  logic            call_valid,
    input  logic [PC_W-1:0] call_pc,
    input  logic            ret_valid
);
    import ftp_pkg::*;

    localparam logic [PC_W-1:0] INSN_BYTES = PC_W'(4);

    logic            tbl_hit;
    logic [PC_W-1:0] tbl_target;
    logic [PC_W-1:0] ras_top;
    logic            ras_top_valid;
    pred_src_e       src;

    ftp_table #(
        .N_ENTRIES(N_ENTRIES),
        .PC_W     (PC_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_pc    (fetch_pc),
        .lk_hit   (tbl_hit),
        .lk_target(tbl_target),
        .up_valid (res_valid),
        .up_pc    (res_pc),
        .up_target(res_target),
        .up_taken (res_taken)
    );

    ftp_ras #(
        .DEPTH(RAS_DEPTH),
        .PC_W (PC_W)
    ) u_ras (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (call_valid),
        .push_addr(call_pc + INSN_BYTES),
        .pop      (ret_valid),
        .top_addr (ras_top),
        .top_valid(ras_top_valid)
    );

    always_comb begin
        if (fetch_is_ret && ras_top_valid) src = SRC_STACK;
        else if (tbl_hit)                  src = SRC_TABLE;
        else                               src = SRC_SEQ;
    end

    always_comb begin
        unique case (src)
            SRC_STACK: next_pc = ras_top;
            SRC_TABLE: next_pc = tbl_target;
            default:   next_pc = fetch_pc + INSN_BYTES;
        endcase
    end

    assign redirect    = (src != SRC_SEQ);
    assign from_stack  = (src == SRC_STACK);
    assign stack_valid = ras_top_valid;

    p_ret_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_is_ret && ras_top_valid) |-> (next_pc == ras_top && from_stack));

    p_table_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_hit && !(fetch_is_ret && ras_top_valid)) |-> (next_pc == tbl_target && redirect));

endmodule

// File: tb/fetch_target_predictor_bench.sv
module fetch_target_predictor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        fetch_is_ret = 1'b0;
    logic [31:0] next_pc;
    logic        redirect, from_stack, stack_valid;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0, res_target = '0;
    logic        res_taken = 1'b0;
    logic        call_valid = 1'b0;
    logic [31:0] call_pc = '0;
    logic        ret_valid = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_v   [64];
    logic [31:0] m_tag [64];
    logic [31:0] m_tgt [64];
    logic [31:0] m_stk [$];

    always #2 clk = ~clk;

    fetch_target_predictor u_fetch_target_predictor (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_is_ret(fetch_is_ret),
        .next_pc(next_pc), .redirect(redirect), .from_stack(from_stack),
        .stack_valid(stack_valid), .res_valid(res_valid), .res_pc(res_pc),
        .res_target(res_target), .res_taken(res_taken), .call_valid(call_valid),
        .call_pc(call_pc), .ret_valid(ret_valid)
    );

    function automatic logic [31:0] exp_next(input logic [31:0] pc, input logic isret);
        int i = int'(pc[7:2]);
        if (isret && m_stk.size() > 0) return m_stk[m_stk.size()-1];
        if (m_v[i] && m_tag[i] == pc) return m_tgt[i];
        return pc + 32'd4;
    endfunction

    function automatic logic exp_redir(input logic [31:0] pc, input logic isret);
        int i = int'(pc[7:2]);
        return (isret && m_stk.size() > 0) || (m_v[i] && m_tag[i] == pc);
    endfunction

    task automatic model_update();
        int i = int'(res_pc[7:2]);
        if (res_valid) begin
            if (res_taken) begin
                m_v[i] = 1'b1; m_tag[i] = res_pc; m_tgt[i] = res_target;
            end else if (m_v[i] && m_tag[i] == res_pc) begin
                m_v[i] = 1'b0;
            end
        end
        if (ret_valid && m_stk.size() > 0) void'(m_stk.pop_back());
        if (call_valid) begin
            if (m_stk.size() == 8) void'(m_stk.pop_front());
            m_stk.push_back(call_pc + 32'd4);
        end
    endtask

    task automatic step(input string req, input logic [31:0] fpc, input logic fret,
                        input logic rv, input logic [31:0] rp, input logic [31:0] rt,
                        input logic rtk, input logic cv, input logic [31:0] cp,
                        input logic retv);
        logic [31:0] e_pc;
        logic e_rd, e_fs, e_sv;
        fetch_pc = fpc; fetch_is_ret = fret;
        res_valid = rv; res_pc = rp; res_target = rt; res_taken = rtk;
        call_valid = cv; call_pc = cp; ret_valid = retv;
        #1;
        e_pc = exp_next(fpc, fret);
        e_rd = exp_redir(fpc, fret);
        e_fs = fret && (m_stk.size() > 0);
        e_sv = (m_stk.size() > 0);
        checks++;
        if (next_pc !== e_pc || redirect !== e_rd || from_stack !== e_fs || stack_valid !== e_sv) begin
            errors++;
            $display("FAIL %s: next_pc=%h redirect=%b from_stack=%b stack_valid=%b expected %h %b %b %b",
                     req, next_pc, redirect, from_stack, stack_valid, e_pc, e_rd, e_fs, e_sv);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic look(input string req, input logic [31:0] fpc, input logic fret);
        step(req, fpc, fret, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) begin m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R4 sequential
        look("R1", 32'h0000_1010, 1'b0);
        look("R1", 32'h0000_1010, 1'b1);
        look("R4", 32'h0000_20fc, 1'b0);

        // R5 write taken entry, then R3 hit
        step("R5", 32'h0, 1'b0, 1'b1, 32'h0000_1010, 32'h0000_4000, 1'b1, 1'b0, '0, 1'b0);
        look("R3", 32'h0000_1010, 1'b0);
        // R2 alias same index, different upper bits
        look("R2", 32'h0000_2010, 1'b0);
        // R6 not-taken with different tag leaves entry
        step("R6", 32'h0, 1'b0, 1'b1, 32'h0000_2010, 32'h0, 1'b0, 1'b0, '0, 1'b0);
        look("R6", 32'h0000_1010, 1'b0);
        // R5 overwrite with new target
        step("R5", 32'h0, 1'b0, 1'b1, 32'h0000_1010, 32'h0000_5554, 1'b1, 1'b0, '0, 1'b0);
        look("R5", 32'h0000_1010, 1'b0);
        // R6 matching not-taken clears
        step("R6", 32'h0, 1'b0, 1'b1, 32'h0000_1010, 32'h0, 1'b0, 1'b0, '0, 1'b0);
        look("R6", 32'h0000_1010, 1'b0);

        // R7 push and priority over table
        step("R5", 32'h0, 1'b0, 1'b1, 32'h0000_3020, 32'h0000_7000, 1'b1, 1'b1, 32'h0000_0100, 1'b0);
        look("R7", 32'h0000_3020, 1'b1);
        look("R3", 32'h0000_3020, 1'b0);
        step("R9", 32'h0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b1);
        // R9 empty stack: return falls back to table
        look("R9", 32'h0000_3020, 1'b1);
        step("R9", 32'h0000_3020, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b1);
        look("R9", 32'h0000_0040, 1'b1);

        // R8 overflow: ten pushes, ten pops
        for (int k = 0; k < 10; k++)
            step("R8", 32'h0000_0040, 1'b1, 1'b0, '0, '0, 1'b0, 1'b1, 32'h0000_9000 + 32'(k*16), 1'b0);
        for (int k = 0; k < 10; k++)
            step("R8", 32'h0000_0040, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b1);
        look("R9", 32'h0000_0040, 1'b1);

        // R10 call and return together: empty then nonempty, then on full
        step("R10", 32'h0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b1, 32'h0000_a000, 1'b1);
        step("R10", 32'h0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b1, 32'h0000_b000, 1'b1);
        look("R10", 32'h0, 1'b1);
        for (int k = 0; k < 8; k++)
            step("R8", 32'h0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b1, 32'h0000_c000 + 32'(k*4), 1'b0);
        step("R10", 32'h0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b1, 32'h0000_d000, 1'b1);
        for (int k = 0; k < 9; k++)
            step("R10", 32'h0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b1);

        // random mix: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] fpc, rpc;
            fpc = (($urandom % 2) ? 32'h0000_1000 : 32'h0000_2000) | 32'(($urandom % 16) << 2);
            rpc = (($urandom % 2) ? 32'h0000_1000 : 32'h0000_2000) | 32'(($urandom % 16) << 2);
            step("R3", fpc, ($urandom % 4) == 0,
                 ($urandom % 3) == 0, rpc, 32'h0008_0000 | 32'($urandom % 65536) << 2,
                 ($urandom % 3) != 0,
                 ($urandom % 6) == 0, 32'($urandom % 65536) << 2,
                 ($urandom % 6) == 0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule